// File: doc/BRIEF.md
# DDR3 Power-Up and Calibration Sequencer

This block is a controller-side state machine that takes a DDR3 device from reset to operational. It drives a DFI-style command bus: device reset, clock enable, the four command strobes, bank address, row address and termination enable. It first holds the device in reset and then waits out the power-on delays. It releases the clock enable, waits out the exit time and then loads the four mode registers with full configured words. Next it starts long ZQ calibration and waits for DLL lock and calibration to complete.

After calibration the sequencer sets the write-leveling bit in MR1 and waits for the register to take effect. It then turns on termination and hands control to an external leveling engine through a start pulse, an active level and a done input. When the engine reports done, the sequencer reloads MR2 with the dynamic termination setting and reloads MR1 with leveling cleared. It then raises a sticky ready flag. Every delay is a cycle-count parameter.

Top module: `ddr3_init_seq`

## Requirements
- R1: After `rst` is released, `dram_reset_n` stays low for exactly T_RST cycles. While it is low, `dram_cke` is low and the bus carries NOP.
- R2: `dram_cke` rises T_CKE cycles after `dram_reset_n` rises when `rdpath_ready` is already high. If `rdpath_ready` arrives after that delay, `dram_cke` rises in the cycle after the one in which `rdpath_ready` is first high.
- R3: `dram_cke` stays high once raised. The first MRS is issued exactly T_XPR cycles after `dram_cke` rises.
- R4: MRS is encoded as cs_n, ras_n, cas_n and we_n all low. The first four MRS commands target banks 2, 3, 1 and 0 in that order, and each follows the previous one by exactly T_MRD cycles.
- R5: Every MRS drives the whole register word. With default parameters the first pass loads MR2=0x0008 (CWL 6 in bits [5:3], dynamic ODT off), MR3=0x0000 (bit 2, MPR, clear), MR1=0x0004 (nominal termination bit 2, bit 7 clear) and MR0=0x0520 (DLL reset bit 8, CL 6 as 010 in bits [6:4], write recovery code 010 in bits [11:9]).
- R6: ZQCL is issued T_MRD cycles after the MR0 load. It is encoded as cs_n low, ras_n high, cas_n high, we_n low, with bank 0 and address 0x0400 (bit 10 set).
- R7: The next command, an MR1 load with bit 7 set (0x0084 by default), comes exactly max(T_DLLK, T_ZQINIT) cycles after ZQCL.
- R8: `dram_odt` and `lvl_active` rise together T_MOD cycles after the leveling MR1 load, and they are always equal. `lvl_start` is high only in the cycle in which they rise.
- R9: The sequencer waits for `lvl_done` without any time limit. In the cycle after `lvl_done` is first sampled high, `dram_odt` and `lvl_active` fall and MR2 is loaded with dynamic ODT enabled (0x0208 by default).
- R10: MR1 is loaded with bit 7 clear (0x0004) T_MRD cycles after that MR2. `init_complete` rises T_MOD cycles later and stays high until `rst`.
- R11: Every cycle that carries no MRS or ZQCL carries NOP: cs_n low, ras_n, cas_n and we_n high, bank and address zero. No command follows `init_complete`.
- R12: A synchronous `rst` at any point drives `dram_reset_n`, `dram_cke`, `dram_odt`, `lvl_active` and `init_complete` low on the next clock, and the full sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdpath_ready | input | 1 | Read path initialised; gates the clock-enable release |
| lvl_done | input | 1 | Leveling engine finished |
| lvl_start | output | 1 | One-cycle leveling start pulse |
| lvl_active | output | 1 | High while leveling is in progress |
| dram_reset_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Clock enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_bank | output | 3 | Bank address |
| dram_addr | output | ADDR_W | Address / mode-register word |
| dram_odt | output | 1 | On-die termination enable |
| init_complete | output | 1 | Sequence finished, sticky until reset |

## Verification
If the state register lands in the wrong state, the next command on the bus has the wrong bank or the wrong word, or it appears out of order. This shows up as a mismatch at the very next command. If the shared delay counter slips, the fault appears at the next command, termination edge or ready edge as a gap that is off by cycles, so it is seen within one programmed delay. A fault in the leveling handshake shows as termination and the active flag disagreeing, or as a start pulse that is missing or stretched, on the cycle in which it happens.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    localparam int MR_W      = 16;
    localparam int BA_W      = 3;
    localparam int ZQ_A_BIT  = 10;

    typedef enum logic [3:0] {
        ST_RST, ST_CKE, ST_XPR,
        ST_MR2, ST_MR3, ST_MR1, ST_MR0,
        ST_ZQ, ST_WL_MR1, ST_WL_RUN,
        ST_MR2_FIN, ST_MR1_FIN, ST_DONE
    } init_state_e;

    typedef enum logic [1:0] {OP_NOP, OP_MRS, OP_ZQCL} dram_op_e;

    typedef struct packed {
        dram_op_e            op;
        logic [BA_W-1:0]     bank;
        logic [MR_W-1:0]     addr;
    } cmd_req_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_pins_t op_pins(input dram_op_e op);
        cmd_pins_t p;
        case (op)
            OP_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            OP_ZQCL: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    // Mode register 0: burst, CAS latency, DLL reset, write recovery
    function automatic logic [MR_W-1:0] mr0_word(input int unsigned cl, input logic [2:0] wr,
                                                 input logic bt, input logic [1:0] bl);
        logic [MR_W-1:0] w;
        w        = '0;
        w[1:0]   = bl;
        w[3]     = bt;
        w[6:4]   = 3'(cl - 4);
        w[8]     = 1'b1;
        w[11:9]  = wr;
        return w;
    endfunction

    // Mode register 1: nominal termination split over bits 9/6/2, additive latency, leveling
    function automatic logic [MR_W-1:0] mr1_word(input logic [2:0] rtt_nom, input logic [1:0] al,
                                                 input logic wl_en);
        logic [MR_W-1:0] w;
        w       = '0;
        w[2]    = rtt_nom[0];
        w[6]    = rtt_nom[1];
        w[9]    = rtt_nom[2];
        w[4:3]  = al;
        w[7]    = wl_en;
        return w;
    endfunction

    // Mode register 2: CAS write latency and dynamic termination
    function automatic logic [MR_W-1:0] mr2_word(input int unsigned cwl, input logic [1:0] rtt_wr);
        logic [MR_W-1:0] w;
        w        = '0;
        w[5:3]   = 3'(cwl - 5);
        w[10:9]  = rtt_wr;
        return w;
    endfunction

    // Mode register 3: MPR kept in normal operation
    function automatic logic [MR_W-1:0] mr3_word();
        return '0;
    endfunction

endpackage

// File: rtl/init_delay_timer.sv
module init_delay_timer #(
    parameter int          CNT_W    = 8,
    parameter int unsigned RST_LOAD = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_LOAD);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mr_word_gen.sv
module mr_word_gen import ddr3_init_pkg::*; #(
    parameter int unsigned CL      = 6,
    parameter int unsigned CWL     = 6,
    parameter logic [2:0]  WR_CODE = 3'b010,
    parameter logic [2:0]  RTT_NOM = 3'b001,
    parameter logic [1:0]  RTT_WR  = 2'b01,
    parameter logic [1:0]  AL      = 2'b00,
    parameter logic [1:0]  BL      = 2'b00,
    parameter logic        BT      = 1'b0
) (
    input  logic [1:0]      sel,
    input  logic            wl_en,
    input  logic            rtt_wr_on,
    output logic [MR_W-1:0] word
);
    logic [3:0][MR_W-1:0] tbl;

    for (genvar g = 0; g < 4; g++) begin : g_mr
        if (g == 0) begin : g_r0
            assign tbl[g] = mr0_word(CL, WR_CODE, BT, BL);
        end else if (g == 1) begin : g_r1
            assign tbl[g] = mr1_word(RTT_NOM, AL, wl_en);
        end else if (g == 2) begin : g_r2
            assign tbl[g] = mr2_word(CWL, rtt_wr_on ? RTT_WR : 2'b00);
        end else begin : g_r3
            assign tbl[g] = mr3_word();
        end
    end

    assign word = tbl[sel];
endmodule

// File: rtl/cmd_encoder.sv
module cmd_encoder import ddr3_init_pkg::*; #(
    parameter int ADDR_W = 16
) (
    input  cmd_req_t          req,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   bank,
    output logic [ADDR_W-1:0] addr
);
    cmd_pins_t pins;

    always_comb begin
        pins = op_pins(req.op);
        cs_n  = pins.cs_n;
        ras_n = pins.ras_n;
        cas_n = pins.cas_n;
        we_n  = pins.we_n;
        if (req.op == OP_NOP) begin
            bank = '0;
            addr = '0;
        end else begin
            bank = req.bank;
            addr = ADDR_W'(req.addr);
        end
    end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq import ddr3_init_pkg::*; #(
    parameter int          ADDR_W   = 16,
    parameter int unsigned T_RST    = 20,
    parameter int unsigned T_CKE    = 30,
    parameter int unsigned T_XPR    = 12,
    parameter int unsigned T_MRD    = 4,
    parameter int unsigned T_MOD    = 12,
    parameter int unsigned T_DLLK   = 64,
    parameter int unsigned T_ZQINIT = 48,
    parameter int unsigned CL       = 6,
    parameter int unsigned CWL      = 6,
    parameter logic [2:0]  WR_CODE  = 3'b010,
    parameter logic [2:0]  RTT_NOM  = 3'b001,
    parameter logic [1:0]  RTT_WR   = 2'b01,
    parameter logic [1:0]  AL       = 2'b00,
    parameter logic [1:0]  BL       = 2'b00,
    parameter logic        BT       = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdpath_ready,
    input  logic              lvl_done,
    output logic              lvl_start,
    output logic              lvl_active,
    output logic              dram_reset_n,
    output logic              dram_cke,
    output logic              dram_cs_n,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [BA_W-1:0]   dram_bank,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_odt,
    output logic              init_complete
);
    localparam int unsigned T_ZQW = max2(T_DLLK, T_ZQINIT);
    localparam int unsigned T_MAX = max2(max2(max2(T_RST, T_CKE), max2(T_XPR, T_MRD)),
                                         max2(T_MOD, T_ZQW));
    localparam int          CNT_W = $clog2(T_MAX + 1);

    init_state_e      state_q, state_d;
    logic             first_q;
    logic             advance;
    logic             expired;
    logic [CNT_W-1:0] load_val;
    int unsigned      dur;

    logic [1:0]       mr_sel;
    logic             wl_en, rtt_wr_on;
    logic [MR_W-1:0]  mr_word;
    dram_op_e         op_d;
    logic [BA_W-1:0]  bank_d;
    cmd_req_t         req;

    // next state and the condition that lets the current wait end
    always_comb begin
        state_d = state_q;
        advance = expired;
        case (state_q)
            ST_RST:     state_d = ST_CKE;
            ST_CKE:     begin state_d = ST_XPR; advance = expired && rdpath_ready; end
            ST_XPR:     state_d = ST_MR2;
            ST_MR2:     state_d = ST_MR3;
            ST_MR3:     state_d = ST_MR1;
            ST_MR1:     state_d = ST_MR0;
            ST_MR0:     state_d = ST_ZQ;
            ST_ZQ:      state_d = ST_WL_MR1;
            ST_WL_MR1:  state_d = ST_WL_RUN;
            ST_WL_RUN:  begin state_d = ST_MR2_FIN; advance = lvl_done; end
            ST_MR2_FIN: state_d = ST_MR1_FIN;
            ST_MR1_FIN: state_d = ST_DONE;
            ST_DONE:    advance = 1'b0;
            default:    state_d = ST_RST;
        endcase
    end

    // length of the state being entered
    always_comb begin
        case (state_d)
            ST_CKE:                                  dur = T_CKE;
            ST_XPR:                                  dur = T_XPR;
            ST_MR2, ST_MR3, ST_MR1, ST_MR0, ST_MR2_FIN: dur = T_MRD;
            ST_ZQ:                                   dur = T_ZQW;
            ST_WL_MR1, ST_MR1_FIN:                   dur = T_MOD;
            default:                                 dur = 1;
        endcase
        load_val = CNT_W'(dur - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RST;
            first_q <= 1'b0;
        end else if (advance) begin
            state_q <= state_d;
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
        end
    end

    init_delay_timer #(
        .CNT_W    (CNT_W),
        .RST_LOAD (T_RST - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (load_val),
        .expired  (expired)
    );

    // command chosen in the first cycle of each command state
    always_comb begin
        op_d      = OP_NOP;
        bank_d    = '0;
        mr_sel    = 2'd0;
        wl_en     = 1'b0;
        rtt_wr_on = 1'b0;
        if (first_q) begin
            case (state_q)
                ST_MR2:     begin op_d = OP_MRS; bank_d = 3'd2; mr_sel = 2'd2; end
                ST_MR3:     begin op_d = OP_MRS; bank_d = 3'd3; mr_sel = 2'd3; end
                ST_MR1:     begin op_d = OP_MRS; bank_d = 3'd1; mr_sel = 2'd1; end
                ST_MR0:     begin op_d = OP_MRS; bank_d = 3'd0; mr_sel = 2'd0; end
                ST_ZQ:      op_d = OP_ZQCL;
                ST_WL_MR1:  begin op_d = OP_MRS; bank_d = 3'd1; mr_sel = 2'd1; wl_en = 1'b1; end
                ST_MR2_FIN: begin op_d = OP_MRS; bank_d = 3'd2; mr_sel = 2'd2; rtt_wr_on = 1'b1; end
                ST_MR1_FIN: begin op_d = OP_MRS; bank_d = 3'd1; mr_sel = 2'd1; end
                default:    op_d = OP_NOP;
            endcase
        end
    end

    mr_word_gen #(
        .CL (CL), .CWL (CWL), .WR_CODE (WR_CODE), .RTT_NOM (RTT_NOM),
        .RTT_WR (RTT_WR), .AL (AL), .BL (BL), .BT (BT)
    ) u_mr (
        .sel       (mr_sel),
        .wl_en     (wl_en),
        .rtt_wr_on (rtt_wr_on),
        .word      (mr_word)
    );

    always_comb begin
        req.op   = op_d;
        req.bank = bank_d;
        if (op_d == OP_MRS) begin
            req.addr = mr_word;
        end else if (op_d == OP_ZQCL) begin
            req.addr = MR_W'(1) << ZQ_A_BIT;
        end else begin
            req.addr = '0;
        end
    end

    cmd_encoder #(.ADDR_W (ADDR_W)) u_enc (
        .req   (req),
        .cs_n  (dram_cs_n),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .we_n  (dram_we_n),
        .bank  (dram_bank),
        .addr  (dram_addr)
    );

    assign dram_reset_n  = (state_q != ST_RST);
    assign dram_cke      = (state_q != ST_RST) && (state_q != ST_CKE);
    assign dram_odt      = (state_q == ST_WL_RUN);
    assign lvl_active    = (state_q == ST_WL_RUN);
    assign lvl_start     = (state_q == ST_WL_RUN) && first_q;
    assign init_complete = (state_q == ST_DONE);
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk #(
    parameter int unsigned T_MRD = 4,
    parameter int unsigned T_XPR = 12
) (
    input logic clk,
    input logic rst,
    input logic reset_n,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic lvl_start,
    input logic init_complete
);
    localparam int unsigned SAT = 32'h0000_ffff;

    logic        is_mrs;
    logic        seen_mrs;
    int unsigned mrs_gap;
    int unsigned cke_age;

    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_mrs <= 1'b0;
            mrs_gap  <= 0;
            cke_age  <= 0;
        end else begin
            if (is_mrs) begin
                seen_mrs <= 1'b1;
                mrs_gap  <= 1;
            end else if (mrs_gap < SAT) begin
                mrs_gap <= mrs_gap + 1;
            end
            if (!cke) begin
                cke_age <= 0;
            end else if (cke_age < SAT) begin
                cke_age <= cke_age + 1;
            end
        end
    end

    p_cke_low_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
        !reset_n |-> !cke);

    p_nop_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
        !reset_n |-> (!cs_n && ras_n && cas_n && we_n));

    p_cke_held_r3: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    p_xpr_before_mrs_r3: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (cke && cke_age >= T_XPR));

    p_mrs_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && seen_mrs) |-> (mrs_gap >= T_MRD));

    p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        lvl_start |=> !lvl_start);

    p_complete_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        init_complete |=> init_complete);

    p_reset_forces_idle_r12: assert property (@(posedge clk)
        rst |=> (!reset_n && !cke && !init_complete));
endmodule

bind ddr3_init_seq init_seq_chk #(.T_MRD (T_MRD), .T_XPR (T_XPR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reset_n       (dram_reset_n),
    .cke           (dram_cke),
    .cs_n          (dram_cs_n),
    .ras_n         (dram_ras_n),
    .cas_n         (dram_cas_n),
    .we_n          (dram_we_n),
    .lvl_start     (lvl_start),
    .init_complete (init_complete)
);

// File: tb/test_ddr3_init_seq.sv
module test_ddr3_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 16;
    localparam int T_RST    = 20;
    localparam int T_CKE    = 30;
    localparam int T_XPR    = 12;
    localparam int T_MRD    = 4;
    localparam int T_MOD    = 12;
    localparam int T_DLLK   = 64;
    localparam int T_ZQINIT = 48;
    localparam int T_ZQW    = (T_DLLK > T_ZQINIT) ? T_DLLK : T_ZQINIT;
    localparam int G_READY  = -1;
    localparam int G_DONE   = -2;

    typedef enum int {EV_RSTN, EV_CKE, EV_ODT_ON, EV_ODT_OFF, EV_MRS, EV_ZQ, EV_DONE} ev_e;
    typedef struct {
        ev_e   kind;
        int    bank;
        int    addr;
        int    gap;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rdpath_ready = 1'b0;
    logic lvl_done = 1'b0;
    logic lvl_start, lvl_active, dram_reset_n, dram_cke;
    logic dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, dram_odt, init_complete;
    logic [2:0] dram_bank;
    logic [ADDR_W-1:0] dram_addr;

    int total = 0;
    int bad = 0;
    exp_t q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr3_init_seq #(
        .ADDR_W (ADDR_W), .T_RST (T_RST), .T_CKE (T_CKE), .T_XPR (T_XPR),
        .T_MRD (T_MRD), .T_MOD (T_MOD), .T_DLLK (T_DLLK), .T_ZQINIT (T_ZQINIT)
    ) i_ddr3_init_seq (
        .clk (clk), .rst (rst), .rdpath_ready (rdpath_ready), .lvl_done (lvl_done),
        .lvl_start (lvl_start), .lvl_active (lvl_active),
        .dram_reset_n (dram_reset_n), .dram_cke (dram_cke),
        .dram_cs_n (dram_cs_n), .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
        .dram_bank (dram_bank), .dram_addr (dram_addr),
        .dram_odt (dram_odt), .init_complete (init_complete)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input ev_e k, input int b, input int a, input int g, input string t);
        exp_t e;
        e.kind = k; e.bank = b; e.addr = a; e.gap = g; e.tag = t;
        q.push_back(e);
    endtask

    // ---------------- monitor ----------------
    int  cyc = 0;
    int  last_cyc = 0;
    int  ready_cyc = -1;
    int  done_cyc = -1;
    bit  in_reset = 1'b1;
    bit  p_rstn, p_cke, p_odt, p_done;

    task automatic got(input ev_e k, input int b, input int a);
        exp_t e;
        int   g;
        if (q.size() == 0) begin
            check(1'b0, "R11", "unexpected event", int'(k), -1);
            return;
        end
        e = q.pop_front();
        g = cyc - last_cyc;
        check(k == e.kind, e.tag, "event kind", int'(k), int'(e.kind));
        if (k == EV_MRS || k == EV_ZQ) begin
            check(b == e.bank, e.tag, "bank", b, e.bank);
            check(a == e.addr, e.tag, "address word", a, e.addr);
        end
        if (e.gap >= 0)
            check(g == e.gap, e.tag, "cycle gap", g, e.gap);
        else if (e.gap == G_READY)
            check(cyc - ready_cyc == 1, e.tag, "gap after ready", cyc - ready_cyc, 1);
        else
            check(cyc - done_cyc == 1, e.tag, "gap after done", cyc - done_cyc, 1);
        last_cyc = cyc;
    endtask

    always @(negedge clk) begin
        bit is_nop, is_mrs, is_zq, odt_rise;
        cyc++;
        if (rst) begin
            in_reset  = 1'b1;
            ready_cyc = -1;
            done_cyc  = -1;
        end else begin
            if (in_reset) begin
                in_reset = 1'b0;
                last_cyc = cyc;
                p_rstn = 1'b0; p_cke = 1'b0; p_odt = 1'b0; p_done = 1'b0;
            end
            if (rdpath_ready && ready_cyc < 0) ready_cyc = cyc;
            if (lvl_active && lvl_done && done_cyc < 0) done_cyc = cyc;

            is_nop = !dram_cs_n && dram_ras_n && dram_cas_n && dram_we_n
                     && dram_bank == 0 && dram_addr == 0;
            is_mrs = !dram_cs_n && !dram_ras_n && !dram_cas_n && !dram_we_n;
            is_zq  = !dram_cs_n && dram_ras_n && dram_cas_n && !dram_we_n;
            odt_rise = dram_odt && !p_odt;

            // R11: only NOP, MRS or ZQCL on the bus
            check(is_nop || is_mrs || is_zq, "R11", "bus encoding",
                  {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, 4'b0111);
            // R1: clock enable low while the device is in reset
            if (!dram_reset_n) check(!dram_cke, "R1", "cke during reset", dram_cke, 0);
            // R8: termination tracks the active flag, start only on its rise
            check(dram_odt == lvl_active, "R8", "odt vs active", dram_odt, lvl_active);
            check(lvl_start == odt_rise, "R8", "start pulse", lvl_start, odt_rise);
            // R10: ready flag is sticky
            if (p_done) check(init_complete, "R10", "complete sticky", init_complete, 1);

            if (dram_reset_n && !p_rstn) got(EV_RSTN, 0, 0);
            if (dram_cke && !p_cke) got(EV_CKE, 0, 0);
            if (odt_rise) got(EV_ODT_ON, 0, 0);
            if (!dram_odt && p_odt) got(EV_ODT_OFF, 0, 0);
            if (is_mrs) got(EV_MRS, int'(dram_bank), int'(dram_addr));
            if (is_zq) got(EV_ZQ, int'(dram_bank), int'(dram_addr));
            if (init_complete && !p_done) got(EV_DONE, 0, 0);

            p_rstn = dram_reset_n; p_cke = dram_cke; p_odt = dram_odt; p_done = init_complete;
        end
    end

    // ---------------- leveling engine model ----------------
    initial begin
        forever begin
            @(posedge clk); #1;
            if (lvl_start && !rst) begin
                repeat ($urandom_range(3, 30)) @(posedge clk);
                #1 lvl_done = 1'b1;
                @(posedge clk); #1 lvl_done = 1'b0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic push_sequence(input bit late_ready);
        push(EV_RSTN,   0, 0,       T_RST,                      "R1");
        push(EV_CKE,    0, 0,       late_ready ? G_READY : T_CKE, "R2");
        push(EV_MRS,    2, 'h0008,  T_XPR,                      "R3");
        push(EV_MRS,    3, 'h0000,  T_MRD,                      "R4");
        push(EV_MRS,    1, 'h0004,  T_MRD,                      "R4");
        push(EV_MRS,    0, 'h0520,  T_MRD,                      "R5");
        push(EV_ZQ,     0, 'h0400,  T_MRD,                      "R6");
        push(EV_MRS,    1, 'h0084,  T_ZQW,                      "R7");
        push(EV_ODT_ON, 0, 0,       T_MOD,                      "R8");
        push(EV_ODT_OFF,0, 0,       G_DONE,                     "R9");
        push(EV_MRS,    2, 'h0208,  0,                          "R9");
        push(EV_MRS,    1, 'h0004,  T_MRD,                      "R10");
        push(EV_DONE,   0, 0,       T_MOD,                      "R10");
    endtask

    task automatic start_run(input int ready_delay);
        @(posedge clk); #1;
        rst = 1'b1;
        rdpath_ready = (ready_delay == 0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        if (ready_delay > 0) begin
            repeat (ready_delay) @(posedge clk);
            #1 rdpath_ready = 1'b1;
        end
    endtask

    task automatic finish_run();
        while (!init_complete) @(negedge clk);
        repeat (30) @(negedge clk);
        check(q.size() == 0, "R11", "pending expected events", q.size(), 0);
        check(init_complete, "R10", "complete held", init_complete, 1);
    endtask

    initial begin
        // run A: read path ready from the start
        push_sequence(1'b0);
        start_run(0);
        @(negedge clk);
        check(!dram_reset_n && !dram_cke && !init_complete, "R1", "reset state",
              {dram_reset_n, dram_cke, init_complete}, 0);
        finish_run();

        // run B: read path ready arrives long after the power-on delay
        push_sequence(1'b1);
        start_run(90);
        finish_run();

        // run C: reset in the middle of leveling
        push_sequence(1'b0);
        start_run(0);
        while (!dram_odt) @(negedge clk);
        repeat (2) @(negedge clk);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({dram_reset_n, dram_cke, dram_odt, lvl_active, init_complete} == 5'b0,
              "R12", "state after mid-run reset",
              {dram_reset_n, dram_cke, dram_odt, lvl_active, init_complete}, 0);
        q.delete();
        repeat (40) @(posedge clk);

        // run D: full restart after the abort
        push_sequence(1'b0);
        start_run(0);
        finish_run();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule